// File: doc/BRIEF.md
# Portrait RGB Panel Raster Timing Generator

This block produces the raster timing for a parallel RGB panel in tall portrait format: 480 visible pixels per line and 640 visible lines per frame by default. It walks a column counter and a row counter at the pixel rate and decodes them into the panel signals: an active-low horizontal sync, an active-low vertical sync and an active-high data enable. It also registers the pixel word from an upstream source and passes it to the panel, forcing zero outside the visible area.

Each line is ordered as visible pixels, front porch, sync pulse, then back porch. Each frame follows the same order in lines. The default porch and sync widths are 24/8/8 clocks horizontally (520 clocks per line) and 4/2/2 lines vertically (648 lines per frame), which is about 22.15 MHz for a roughly 66 Hz refresh. All widths are parameters.

The column and row outputs give the coordinate of the pixel that the upstream source must present on `pix_in` before the next enabled clock edge. That pixel leaves the block one edge later. Sync outputs and `sof` change on the rising clock edge. `de` and `pix_out` change on the following falling edge, so the panel can sample data and syncs on opposite edges. A `run` input lets a power-up sequencer keep the panel idle until its register setup is done.

Top module: `rgb_raster_gen`

## Requirements
- R1: While reset is asserted, hsync_n and vsync_n are 1, and de, sof, col, row and pix_out are 0.
- R2: Counting the captured horizontal position from 0, a line lasts H_ACT+H_FP+H_SYNC+H_BP enabled clocks (520 by default). hsync_n is 0 exactly for positions H_ACT+H_FP up to H_ACT+H_FP+H_SYNC-1 (504..511 by default) and 1 otherwise.
- R3: The row advances once per line and wraps after V_ACT+V_FP+V_SYNC+V_BP lines. vsync_n is 0 exactly for rows V_ACT+V_FP up to V_ACT+V_FP+V_SYNC-1, and it changes only when the horizontal position 0 of a line is captured.
- R4: de is 1 only for positions with column below H_ACT and row below V_ACT, so a frame holds exactly H_ACT*V_ACT data-enable clocks. de is never 1 while either sync is 0.
- R5: hsync_n, vsync_n and sof change only at rising clock edges. de and pix_out change only at falling edges, half a clock after the sync outputs for the same position.
- R6: pix_out carries the pix_in word captured at the rising edge that captured a visible position, and is 0 for blanking positions.
- R7: col and row show the coordinate to be captured at the next enabled edge. col wraps to 0 after H_ACT+H_FP+H_SYNC+H_BP-1, and row increments when col wraps.
- R8: At a rising edge with pix_ce 0 and run 1, no counter or output changes, except that sof returns to 0.
- R9: At a rising edge with run 0, the counters clear to 0, both syncs go to 1, sof goes to 0, and de and pix_out go to 0 at the next falling edge, whatever pix_ce is. The first enabled edge after run returns to 1 captures position (0,0).
- R10: sof is 1 for exactly one clock after the enabled edge that captures position (0,0), and it coincides with de rising for that position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; syncs update on its rising edge, data on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel-rate enable; the raster advances on rising edges where it is 1 |
| run | input | 1 | 1 lets the raster run; 0 holds the block idle at position (0,0) |
| pix_in | input | PIX_W | Pixel word for the coordinate shown on col/row |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, active high, visible pixels only |
| pix_out | output | PIX_W | Registered pixel word to the panel |
| col | output | $clog2(H_ACT+H_FP+H_SYNC+H_BP) | Column of the next pixel to be supplied |
| row | output | $clog2(V_ACT+V_FP+V_SYNC+V_BP) | Row of the next pixel to be supplied |
| sof | output | 1 | One-clock start-of-frame pulse for position (0,0) |

## Verification
The embedded properties check on every cycle that the idle state follows a low `run`, that a low enable freezes the raster, and that data enable never overlaps a sync pulse. They also check that each sync edge falls at the column where it belongs and that the frame pulse lasts one clock and agrees with data enable. What the properties cannot show is the exact pattern: the pixel words reaching the panel, the half-clock offset between the two edge domains, the data-enable count per frame, and the restart at the first visible pixel after a stop. The bench scenarios show these against a position model kept in the bench. This is done on a small raster, and on the full-size default raster for its line layout.

// File: rtl/rgb_raster_gen.sv
`timescale 1ns/1ps
module rgb_raster_gen #(
  parameter int H_ACT  = 480,
  parameter int H_FP   = 24,
  parameter int H_SYNC = 8,
  parameter int H_BP   = 8,
  parameter int V_ACT  = 640,
  parameter int V_FP   = 4,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 2,
  parameter int PIX_W  = 24,
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP,
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP,
  localparam int HW    = $clog2(H_TOT),
  localparam int VW    = $clog2(V_TOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_ce,
  input  logic             run,
  input  logic [PIX_W-1:0] pix_in,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             de,
  output logic [PIX_W-1:0] pix_out,
  output logic [HW-1:0]    col,
  output logic [VW-1:0]    row,
  output logic             sof
);

  logic [HW-1:0]    h_cnt;
  logic [VW-1:0]    v_cnt;
  logic             de_pre;
  logic [PIX_W-1:0] pix_r;

  wire h_last = h_cnt == HW'(H_TOT - 1);
  wire v_last = v_cnt == VW'(V_TOT - 1);
  wire h_vis  = h_cnt < HW'(H_ACT);
  wire v_vis  = v_cnt < VW'(V_ACT);
  wire h_pul  = (h_cnt >= HW'(H_ACT + H_FP)) && (h_cnt < HW'(H_ACT + H_FP + H_SYNC));
  wire v_pul  = (v_cnt >= VW'(V_ACT + V_FP)) && (v_cnt < VW'(V_ACT + V_FP + V_SYNC));
  wire vis    = h_vis && v_vis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt   <= '0;
      v_cnt   <= '0;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      de_pre  <= 1'b0;
      pix_r   <= '0;
      sof     <= 1'b0;
    end else if (!run) begin
      h_cnt   <= '0;
      v_cnt   <= '0;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      de_pre  <= 1'b0;
      pix_r   <= '0;
      sof     <= 1'b0;
    end else if (pix_ce) begin
      h_cnt   <= h_last ? '0 : h_cnt + 1'b1;
      if (h_last)
        v_cnt <= v_last ? '0 : v_cnt + 1'b1;
      hsync_n <= !h_pul;
      vsync_n <= !v_pul;
      de_pre  <= vis;
      pix_r   <= vis ? pix_in : '0;
      sof     <= (h_cnt == '0) && (v_cnt == '0);
    end else begin
      sof     <= 1'b0;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de      <= 1'b0;
      pix_out <= '0;
    end else begin
      de      <= de_pre;
      pix_out <= pix_r;
    end
  end

  assign col = h_cnt;
  assign row = v_cnt;

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> hsync_n && vsync_n && !sof && col == '0 && row == '0);

  // R8
  ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_ce && run) |=> $stable(hsync_n) && $stable(vsync_n) && $stable(col) && $stable(row));

  // R4
  de_sync_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_pre |-> hsync_n && vsync_n);

  // R2
  hsync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(hsync_n) && $past(run)) |->
      (col == HW'(H_ACT + H_FP + 1) || col == HW'((H_ACT + H_FP + H_SYNC + 1) % H_TOT)));

  // R3
  vsync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(vsync_n) && $past(run)) |-> col == HW'(1));

  // R10
  sof_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !sof);

  // R10
  sof_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> de_pre && row == '0);

endmodule

// File: tb/tb_rgb_raster_gen.sv
`timescale 1ns/1ps
module tb_rgb_raster_gen;
  localparam int HA = 8, HF = 3, HS = 2, HB = 2;
  localparam int VA = 6, VF = 2, VS = 1, VB = 1;
  localparam int PW = 24;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, pix_ce, run;
  logic [PW-1:0] pix_in;
  logic          hs, vs, de, sof;
  logic [PW-1:0] pix_out;
  logic [$clog2(HT)-1:0] col;
  logic [$clog2(VT)-1:0] row;

  rgb_raster_gen #(.H_ACT(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
                   .V_ACT(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .PIX_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .run(run), .pix_in(pix_in),
    .hsync_n(hs), .vsync_n(vs), .de(de), .pix_out(pix_out),
    .col(col), .row(row), .sof(sof));

  logic          run_f;
  logic          hs_f, vs_f, de_f, sof_f;
  logic [23:0]   pix_f;
  logic [9:0]    col_f, row_f;

  rgb_raster_gen dut_full (
    .clk(clk), .rst_n(rst_n), .pix_ce(1'b1), .run(run_f), .pix_in(24'h0),
    .hsync_n(hs_f), .vsync_n(vs_f), .de(de_f), .pix_out(pix_f),
    .col(col_f), .row(row_f), .sof(sof_f));

  int n_chk = 0, n_bad = 0;
  int nx = 0, ny = 0, cx = 0, cy = 0, de_seen = 0;
  bit valid = 0, fresh = 0;
  logic de_prev, hs_m, vs_m;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] want);
    n_chk++;
    if (act !== want) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, want, $time);
    end
  endtask

  function automatic logic [23:0] pat(input int x, input int y);
    pat = {8'(x) + 8'h11, 8'(y) + 8'h22, 8'(x ^ y) ^ 8'h5a};
  endfunction

  // called between a falling and the next rising edge; returns at the same phase
  task automatic step(input bit ce);
    logic hs_e, vs_e, de_e;
    logic [31:0] col_pre;
    col_pre = 32'(col);
    pix_ce = ce;
    pix_in = pat(nx, ny);
    @(posedge clk);
    if (!run) begin
      valid = 0; fresh = 0; nx = 0; ny = 0;
    end else if (ce) begin
      cx = nx; cy = ny; valid = 1; fresh = 1;
      if (nx == HT - 1) begin
        nx = 0;
        ny = (ny == VT - 1) ? 0 : ny + 1;
      end else nx++;
    end else fresh = 0;
    #2;
    hs_e = !(valid && cx >= HA + HF && cx < HA + HF + HS);
    vs_e = !(valid && cy >= VA + VF && cy < VA + VF + VS);
    chk(valid ? "R2 hsync" : "R9 idle hsync", hs, hs_e);
    chk(valid ? "R3 vsync" : "R9 idle vsync", vs, vs_e);
    chk("R10 sof", sof, fresh && cx == 0 && cy == 0);
    chk("R7 col", col, nx);
    chk("R7 row", row, ny);
    chk("R5 de held over rising edge", de, de_prev);
    if (run && !ce) chk("R8 col frozen", col, col_pre);
    hs_m = hs; vs_m = vs;
    #4;
    de_e = valid && cx < HA && cy < VA;
    chk(valid ? "R4 de" : "R9 idle de", de, de_e);
    chk("R6 pixel", pix_out, de_e ? pat(cx, cy) : 24'h0);
    chk("R5 hsync held over falling edge", hs, hs_m);
    chk("R5 vsync held over falling edge", vs, vs_m);
    de_prev = de;
    if (de) de_seen++;
  endtask

  task automatic t_reset;
    rst_n = 0; run = 0; run_f = 0; pix_ce = 0; pix_in = '0;
    @(posedge clk); @(posedge clk); #2;
    chk("R1 hsync", hs, 1); chk("R1 vsync", vs, 1); chk("R1 de", de, 0);
    chk("R1 sof", sof, 0); chk("R1 col", col, 0); chk("R1 row", row, 0);
    chk("R1 pix_out", pix_out, 0);
    #4;
    rst_n = 1;
    de_prev = de;
  endtask

  task automatic t_idle_ignored;
    for (int i = 0; i < 5; i++) step(1'b1);
  endtask

  task automatic t_frames_full;
    run = 1;
    de_seen = 0;
    for (int i = 0; i < HT * VT; i++) step(1'b1);
    chk("R4 de count per frame", de_seen, HA * VA);
    for (int i = 0; i < HT * VT + 7; i++) step(1'b1);
  endtask

  task automatic t_ce_gaps;
    for (int i = 0; i < 400; i++) step((i % 3) != 0);
  endtask

  task automatic t_stop_restart;
    for (int i = 0; i < 37; i++) step(1'b1);
    run = 0;
    for (int i = 0; i < 3; i++) step(i != 1);
    run = 1;
    for (int i = 0; i < HT * VT + 10; i++) step(1'b1);
  endtask

  task automatic t_full_line;
    logic he;
    run_f = 1;
    for (int i = 0; i < 1040; i++) begin
      @(posedge clk); #2;
      he = !((i % 520) >= 504 && (i % 520) < 512);
      chk("R2 default hsync", hs_f, he);
      chk("R3 default vsync", vs_f, 1);
      chk("R7 default col", col_f, (i + 1) % 520);
      chk("R7 default row", row_f, (i + 1) / 520);
      chk("R10 default sof", sof_f, i == 0);
      #4;
      chk("R4 default de", de_f, (i % 520) < 480);
    end
  endtask

  initial begin
    t_reset();
    t_idle_ignored();
    t_frames_full();
    t_ce_gaps();
    t_stop_restart();
    t_full_line();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule